// File: doc/BRIEF.md
# UART Interrupt Status and Masking

This block gathers the eleven interrupt events of a serial port into a raw status register and applies a mask that software programs. From the result it drives six interrupt lines: one that combines every source, three that each follow one source (receive, transmit, receive timeout), and two that follow a group (modem lines, receive errors). The rest of the UART signals each event as a single-cycle set pulse on `evt_set`. This block does not detect the events itself. It only latches them, masks them and combines them.

Software reaches the block through a small word-addressed register port. It can read and write the mask, read the raw status and the masked status, and clear raw bits by writing ones to a clear register. The register reads are combinational on `addr`. All six interrupt lines are registered. A set pulse that meets a clear of the same bit in the same cycle wins, so no event is lost.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A high bit of `evt_set` sets the raw status bit at the same position at the next clock edge, and the bit stays set until it is cleared. The bit positions are: ring indicator 0, clear-to-send 1, carrier detect 2, data-set-ready 3, receive 4, transmit 5, receive timeout 6, framing error 7, parity error 8, break 9, overrun 10.
- R2: A write to word offset 17 clears each raw bit whose `wdata` bit is 1. Raw bits whose `wdata` bit is 0 keep their value. Reads of offset 17 return zero.
- R3: When a set pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R4: Word offset 14 holds the 11-bit mask. Writes load `wdata[10:0]`. Reads return the mask in bits 10:0 and zero in bits 31:11.
- R5: Word offset 15 reads the raw status and word offset 16 reads the raw status ANDed with the mask, both zero-extended. Writes to either offset change nothing.
- R6: `irq_all` is high when any bit of (raw AND mask) is set.
- R7: `irq_rx`, `irq_tx` and `irq_rt` follow masked bits 4, 5 and 6 respectively.
- R8: `irq_ms` is high when any of masked bits 0 to 3 is set. `irq_err` is high when any of masked bits 7 to 10 is set.
- R9: Every interrupt output is registered. It reflects the raw status and mask held during the cycle before the edge, so it changes one cycle after those registers change.
- R10: Reset clears the mask, the raw status and all six interrupt outputs to zero.
- R11: Reads of any offset other than 14, 15 and 16 return zero. Writes to any offset other than 14 and 17 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_set | input | 11 | Single-cycle set pulses, one per interrupt source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 10 | Register word offset |
| wdata | input | 32 | Register write data |
| rd_data | output | 32 | Register read data, combinational on `addr` |
| irq_all | output | 1 | Combined interrupt over all sources |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rt | output | 1 | Receive timeout interrupt |
| irq_ms | output | 1 | Modem line group interrupt |
| irq_err | output | 1 | Receive error group interrupt |

## Verification
The bench targets these corner cases:

- **Set and clear on one bit in one cycle.** A design that lets the clear win drops the event, and a later raw read shows a zero.
- **Writes to the read-only and unmapped offsets.** A loose decoder alters the mask or the status, and the next read reveals it.
- **Upper bits of mask writes.** A design that stores or returns them shows non-zero high bits on readback.
- **Group boundaries.** Bits 3/4 and 6/7 split the groups. A group table shifted by one raises the wrong line, and the lines are compared against a model every cycle.
- **One-cycle output lag.** A design that drives the lines combinationally is off by one cycle on every edge where the status changes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC  = 11;
    localparam int NLINE = 6;

    // source bit positions
    localparam int SRC_RI  = 0;
    localparam int SRC_CTS = 1;
    localparam int SRC_DCD = 2;
    localparam int SRC_DSR = 3;
    localparam int SRC_RX  = 4;
    localparam int SRC_TX  = 5;
    localparam int SRC_RT  = 6;
    localparam int SRC_FE  = 7;
    localparam int SRC_PE  = 8;
    localparam int SRC_BE  = 9;
    localparam int SRC_OE  = 10;

    typedef logic [NSRC-1:0]  src_vec_t;
    typedef logic [NLINE-1:0] line_vec_t;

    // output line order
    localparam int LINE_ALL = 0;
    localparam int LINE_RX  = 1;
    localparam int LINE_TX  = 2;
    localparam int LINE_RT  = 3;
    localparam int LINE_MS  = 4;
    localparam int LINE_ERR = 5;

    localparam src_vec_t GRP_MS  = src_vec_t'((1 << SRC_RI) | (1 << SRC_CTS) |
                                              (1 << SRC_DCD) | (1 << SRC_DSR));
    localparam src_vec_t GRP_ERR = src_vec_t'((1 << SRC_FE) | (1 << SRC_PE) |
                                              (1 << SRC_BE) | (1 << SRC_OE));

    function automatic src_vec_t line_group(input int line);
        src_vec_t g;
        case (line)
            LINE_ALL: g = '1;
            LINE_RX:  g = src_vec_t'(1 << SRC_RX);
            LINE_TX:  g = src_vec_t'(1 << SRC_TX);
            LINE_RT:  g = src_vec_t'(1 << SRC_RT);
            LINE_MS:  g = GRP_MS;
            default:  g = GRP_ERR;
        endcase
        return g;
    endfunction

    typedef struct packed {
        src_vec_t raw;
        src_vec_t mask;
    } irq_state_t;

endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int MASK_OFS = 14,
    parameter int CLR_OFS  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  src_vec_t          evt_set,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output src_vec_t          raw_q,
    output src_vec_t          mask_q
);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_OFS);

    irq_state_t st_d, st_q;
    src_vec_t   clr_bits;
    logic       unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:NSRC];

    always_comb begin
        st_d     = st_q;
        clr_bits = (wr_en && addr == CLR_A) ? wdata[NSRC-1:0] : '0;
        // a set pulse wins over a clear of the same bit
        st_d.raw = (st_q.raw & ~clr_bits) | evt_set;
        if (wr_en && addr == MASK_A) begin
            st_d.mask = wdata[NSRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_q  = st_q.raw;
    assign mask_q = st_q.mask;

endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines
    import uart_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  src_vec_t  raw,
    input  src_vec_t  mask,
    output line_vec_t irq_q
);
    src_vec_t  pend;
    line_vec_t active;
    line_vec_t irq_d;

    assign pend = raw & mask;

    for (genvar k = 0; k < NLINE; k++) begin : g_line
        assign active[k] = |(pend & line_group(k));
    end

    always_comb begin
        irq_d = active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

endmodule

// File: rtl/uart_irq_rdmux.sv
module uart_irq_rdmux
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int MASK_OFS = 14,
    parameter int RAW_OFS  = 15,
    parameter int MIS_OFS  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  src_vec_t          raw,
    input  src_vec_t          mask,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] RAW_A  = ADDR_W'(RAW_OFS);
    localparam logic [ADDR_W-1:0] MIS_A  = ADDR_W'(MIS_OFS);

    always_comb begin
        rd_data = '0;
        case (addr)
            MASK_A:  rd_data[NSRC-1:0] = mask;
            RAW_A:   rd_data[NSRC-1:0] = raw;
            MIS_A:   rd_data[NSRC-1:0] = raw & mask;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int MASK_OFS = 14,
    parameter int RAW_OFS  = 15,
    parameter int MIS_OFS  = 16,
    parameter int CLR_OFS  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [10:0]       evt_set,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_all,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_rt,
    output logic              irq_ms,
    output logic              irq_err
);
    src_vec_t  raw_q;
    src_vec_t  mask_q;
    line_vec_t irq_vec;

    uart_irq_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .MASK_OFS (MASK_OFS),
        .CLR_OFS  (CLR_OFS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_set (evt_set),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .raw_q   (raw_q),
        .mask_q  (mask_q)
    );

    uart_irq_lines u_lines (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_q),
        .mask  (mask_q),
        .irq_q (irq_vec)
    );

    uart_irq_rdmux #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .MASK_OFS (MASK_OFS),
        .RAW_OFS  (RAW_OFS),
        .MIS_OFS  (MIS_OFS)
    ) u_rdmux (
        .addr    (addr),
        .raw     (raw_q),
        .mask    (mask_q),
        .rd_data (rd_data)
    );

    assign irq_all = irq_vec[LINE_ALL];
    assign irq_rx  = irq_vec[LINE_RX];
    assign irq_tx  = irq_vec[LINE_TX];
    assign irq_rt  = irq_vec[LINE_RT];
    assign irq_ms  = irq_vec[LINE_MS];
    assign irq_err = irq_vec[LINE_ERR];

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int MASK_OFS = 14,
    parameter int RAW_OFS  = 15,
    parameter int MIS_OFS  = 16,
    parameter int CLR_OFS  = 17
) (
    input logic              clk,
    input logic              rst_n,
    input src_vec_t          evt_set,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rd_data,
    input src_vec_t          raw_q,
    input src_vec_t          mask_q,
    input logic              irq_all,
    input logic              irq_ms,
    input logic              irq_err
);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] RAW_A  = ADDR_W'(RAW_OFS);
    localparam logic [ADDR_W-1:0] MIS_A  = ADDR_W'(MIS_OFS);
    localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_OFS);

    // R1
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(evt_set)) == '0));

    // R2
    clear_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CLR_A) |=>
            ((raw_q & $past(wdata[NSRC-1:0]) & ~$past(evt_set)) == '0));

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((raw_q & $past(evt_set)) == $past(evt_set)));

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == MASK_A) |=> (mask_q == $past(wdata[NSRC-1:0])));

    // R6
    combined_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_all == (|($past(raw_q) & $past(mask_q)))));

    // R8
    err_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_err == (|($past(raw_q) & $past(mask_q) & GRP_ERR))));

    // R8
    ms_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_ms == (|($past(raw_q) & $past(mask_q) & GRP_MS))));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (raw_q == '0 && mask_q == '0));

    // R11
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != MASK_A && addr != RAW_A && addr != MIS_A) |-> (rd_data == '0));

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MASK_OFS (MASK_OFS),
    .RAW_OFS  (RAW_OFS),
    .MIS_OFS  (MIS_OFS),
    .CLR_OFS  (CLR_OFS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_set (evt_set),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rd_data (rd_data),
    .raw_q   (raw_q),
    .mask_q  (mask_q),
    .irq_all (irq_all),
    .irq_ms  (irq_ms),
    .irq_err (irq_err)
);

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] evt_set = '0;
    logic        wr_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        irq_all, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [10:0] m_raw  = '0;
    logic [10:0] m_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ctrl dut (
        .clk (clk), .rst_n (rst_n), .evt_set (evt_set), .wr_en (wr_en),
        .addr (addr), .wdata (wdata), .rd_data (rd_data),
        .irq_all (irq_all), .irq_rx (irq_rx), .irq_tx (irq_tx),
        .irq_rt (irq_rt), .irq_ms (irq_ms), .irq_err (irq_err)
    );

    function automatic logic [10:0] grp(input int k);
        case (k)
            0: return 11'h7FF;
            1: return 11'h010;
            2: return 11'h020;
            3: return 11'h040;
            4: return 11'h00F;
            default: return 11'h780;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [9:0] a);
        case (a)
            10'd14:  return {21'd0, m_mask};
            10'd15:  return {21'd0, m_raw};
            10'd16:  return {21'd0, m_raw & m_mask};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [9:0] a);
        if (a == 10'd14) return "R4";
        if (a == 10'd15 || a == 10'd16) return "R5";
        return "R11";
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // one clock cycle: drive, check read, advance model, check lines
    task automatic cyc(input logic [10:0] s, input logic w, input logic [9:0] a,
                       input logic [31:0] d, input string rtag);
        logic [10:0] pend;
        logic [5:0]  exp_irq;
        logic [5:0]  got_irq;
        string       t;
        @(negedge clk);
        evt_set = s; wr_en = w; addr = a; wdata = d;
        #1;
        t = (rtag != "") ? rtag : rd_tag(a);
        check(t, rd_data, exp_read(a));
        pend = m_raw & m_mask;
        for (int k = 0; k < 6; k++) exp_irq[k] = |(pend & grp(k));
        m_raw = (m_raw & ~((w && a == 10'd17) ? d[10:0] : 11'd0)) | s;
        if (w && a == 10'd14) m_mask = d[10:0];
        @(posedge clk);
        #1;
        got_irq = {irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_all};
        check("R6 R9 irq_all", {31'd0, got_irq[0]}, {31'd0, exp_irq[0]});
        check("R7 R9 irq_rx/tx/rt", {29'd0, got_irq[3:1]}, {29'd0, exp_irq[3:1]});
        check("R8 R9 irq_ms/err", {30'd0, got_irq[5:4]}, {30'd0, exp_irq[5:4]});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [9:0] a;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: state after reset
        addr = 10'd14; #1;
        check("R10 mask", rd_data, 32'd0);
        check("R10 irq", {26'd0, irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_all}, 32'd0);
        rst_n = 1'b1;
        cyc(11'd0, 1'b0, 10'd15, 32'd0, "R10");

        // R1: each source latches at its own position and holds
        cyc(11'h400, 1'b0, 10'd0, 32'd0, "");
        cyc(11'h001, 1'b0, 10'd15, 32'd0, "R1");
        cyc(11'd0, 1'b0, 10'd15, 32'd0, "R1");

        // R4: mask write with upper bits set, readback zero-extended
        cyc(11'd0, 1'b1, 10'd14, 32'hFFFF_F811, "");
        cyc(11'd0, 1'b0, 10'd14, 32'd0, "R4");
        cyc(11'd0, 1'b0, 10'd16, 32'd0, "R5");

        // R5 / R11: writes to read-only and unmapped offsets ignored
        cyc(11'd0, 1'b1, 10'd15, 32'h0000_07FF, "");
        cyc(11'd0, 1'b1, 10'd16, 32'h0000_07FF, "");
        cyc(11'd0, 1'b1, 10'd13, 32'h0000_07FF, "");
        cyc(11'd0, 1'b1, 10'd18, 32'h0000_0000, "");
        cyc(11'd0, 1'b0, 10'd15, 32'd0, "R5");
        cyc(11'd0, 1'b0, 10'd14, 32'd0, "R11");
        cyc(11'd0, 1'b0, 10'd17, 32'd0, "R2");

        // R2: partial clear leaves other bits
        cyc(11'd0, 1'b1, 10'd17, 32'h0000_0001, "");
        cyc(11'd0, 1'b0, 10'd15, 32'd0, "R2");

        // R3: set and clear of the same bit in the same cycle
        cyc(11'h020, 1'b1, 10'd17, 32'h0000_0420, "");
        cyc(11'd0, 1'b0, 10'd15, 32'd0, "R3");

        // R8: group boundaries, one bit each side
        cyc(11'd0, 1'b1, 10'd17, 32'h0000_07FF, "");
        cyc(11'd0, 1'b1, 10'd14, 32'h0000_07FF, "");
        cyc(11'h008, 1'b0, 10'd16, 32'd0, "");
        cyc(11'h080, 1'b0, 10'd16, 32'd0, "R8");
        cyc(11'h040, 1'b0, 10'd16, 32'd0, "R7");
        cyc(11'h010, 1'b0, 10'd16, 32'd0, "R7");
        cyc(11'd0, 1'b1, 10'd14, 32'h0000_0000, "");
        cyc(11'd0, 1'b0, 10'd16, 32'd0, "R6");

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [10:0] s;
            logic        w;
            case ($urandom % 6)
                0: a = 10'd14;
                1: a = 10'd15;
                2: a = 10'd16;
                3: a = 10'd17;
                4: a = 10'd17;
                default: a = 10'($urandom);
            endcase
            s = 11'($urandom) & 11'($urandom) & 11'($urandom);
            w = ($urandom % 3) == 0;
            cyc(s, w, a, $urandom, "");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule